// File: doc/BRIEF.md
# Opcode-Class Main Control Decoder

This block is the main control decoder of a single-cycle, load/store processor core with 32-bit instructions. It reads the 5-bit opcode at the top of the instruction word. The two most significant opcode bits give the instruction class: two of the four codes mean register type, one means immediate type and one means jump type. The three low opcode bits then pick the operation within the immediate and jump classes. From this the block drives the datapath steering lines, which are register write, destination choice, ALU operand source, memory read and write, load-data return, branch, jump, and a 2-bit ALU-op hint for the ALU decoder.

The decoder is purely combinational, so every output follows the opcode within the same cycle. The block also resolves the 7-bit destination register number from the instruction word. This is the rd field for register type, the rt field for immediate writes, and the fixed return-address register 127 for the linking jump.

Top module: `mdec_main`

## Requirements
- R1: `cls_o` is 1 when opcode bits [4:3] are 01 or 10, 2 when they are 11, and 0 when they are 00. The value 3 never appears. The opcode is instruction bits [31:27].
- R2: Every register-type opcode sets `reg_we_o`=1, `dst_sel_o`=1 (rd), `alu_src_imm_o`=0 and `alu_op_o`=2'b10. It leaves the memory enables, `branch_o` and `jump_o` low.
- R3: `wr_reg_o` is instruction bits [12:6] when `dst_sel_o`=1 and bits [19:13] when `dst_sel_o`=0.
- R4: Opcode 11001 (load) sets `mem_rd_o`, `mem_to_reg_o`, `reg_we_o` and `alu_src_imm_o` to 1, with `dst_sel_o`=0 and `alu_op_o`=2'b00.
- R5: Opcode 11010 (store) sets `mem_wr_o`=1 and `alu_src_imm_o`=1 with `reg_we_o`=0. `mem_rd_o` and `mem_wr_o` are never both 1.
- R6: Opcode 11011 (branch) sets `branch_o`=1 and `alu_op_o`=2'b01 with `alu_src_imm_o`=0. A branch never writes a register or memory.
- R7: Opcode 11000 (add immediate) writes rt with `alu_src_imm_o`=1 and `alu_op_o`=2'b00. Opcode 11100 (logical immediate) does the same with `alu_op_o`=2'b11.
- R8: Opcode 00000 (plain jump) sets `jump_o`=1 and every other control output to 0.
- R9: Opcode 00001 (linking jump) sets `jump_o`=1, `reg_we_o`=1 and `dst_sel_o`=2. In the same cycle `wr_reg_o` is 127, whatever the register fields hold.
- R10: Unassigned opcodes (11101 to 11111 and 00010 to 00111) hold `reg_we_o`, `mem_rd_o`, `mem_wr_o`, `mem_to_reg_o`, `branch_o`, `jump_o` and `alu_op_o` at 0.
- R11: The control outputs (all except `wr_reg_o`) depend only on bits [31:27]. Changing bits [26:0] leaves them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Current instruction word |
| cls_o | output | 2 | Instruction class: 0 jump, 1 register, 2 immediate |
| reg_we_o | output | 1 | Register file write enable |
| dst_sel_o | output | 2 | Destination choice: 0 rt, 1 rd, 2 return address |
| wr_reg_o | output | 7 | Resolved destination register number |
| alu_src_imm_o | output | 1 | ALU operand B from the extended immediate |
| mem_rd_o | output | 1 | Data memory read |
| mem_wr_o | output | 1 | Data memory write |
| mem_to_reg_o | output | 1 | Write-back data taken from memory |
| branch_o | output | 1 | Conditional branch |
| jump_o | output | 1 | Unconditional jump |
| alu_op_o | output | 2 | ALU-op hint: 00 add, 01 subtract compare, 10 use function field, 11 logical |

## Verification
The linking jump is the one opcode where a jump and a register write happen in the same cycle. That same cycle must also force the destination to register 127 over the instruction's rd and rt fields. The bench drives 00001 with register fields set to values far from 127, and checks that `jump_o`, `reg_we_o` and `wr_reg_o`=127 all appear in one sample. The load is the other combined case: it checks that the memory read and the register write-back are raised together while the memory write stays low.

// File: rtl/mdec_pkg.sv
package mdec_pkg;

   typedef enum logic [1:0] {
      CLS_JMP = 2'd0,
      CLS_REG = 2'd1,
      CLS_IMM = 2'd2
   } iclass_e;

   typedef enum logic [1:0] {
      DST_RT = 2'd0,
      DST_RD = 2'd1,
      DST_RA = 2'd2
   } dst_e;

   typedef struct packed {
      logic       reg_we;
      dst_e       dst;
      logic       alu_src_imm;
      logic       mem_rd;
      logic       mem_wr;
      logic       mem_to_reg;
      logic       branch;
      logic       jump;
      logic [1:0] alu_op;
   } ctrl_t;

   localparam logic [1:0] AOP_ADD   = 2'b00;
   localparam logic [1:0] AOP_SUB   = 2'b01;
   localparam logic [1:0] AOP_FUNCT = 2'b10;
   localparam logic [1:0] AOP_LOGIC = 2'b11;

   // low opcode bits inside the immediate class
   localparam int unsigned SUB_ADDI  = 0;
   localparam int unsigned SUB_LOAD  = 1;
   localparam int unsigned SUB_STORE = 2;
   localparam int unsigned SUB_BR    = 3;
   localparam int unsigned SUB_LOGI  = 4;
   // low opcode bits inside the jump class
   localparam int unsigned SUB_JMP   = 0;
   localparam int unsigned SUB_JAL   = 1;

endpackage

// File: rtl/mdec_class.sv
module mdec_class
   import mdec_pkg::*;
#(
   parameter int unsigned OP_W = 5
) (
   input  logic [OP_W-1:0] op_i,
   output iclass_e         cls_o
);

   localparam int unsigned TOP_HI = OP_W - 1;
   localparam int unsigned TOP_LO = OP_W - 2;

   generate
      if (OP_W < 3) begin : g_bad_op_w
         $error("mdec_class: OP_W must leave at least one sub-opcode bit");
      end
   endgenerate

   always_comb begin
      unique case (op_i[TOP_HI:TOP_LO])
         2'b00:   cls_o = CLS_JMP;
         2'b11:   cls_o = CLS_IMM;
         default: cls_o = CLS_REG;
      endcase
   end

   always_comb begin
      p_class_legal_r1: assert (cls_o != iclass_e'(2'd3))
         else $error("R1 class code 3 produced");
   end

endmodule

// File: rtl/mdec_ctrl.sv
module mdec_ctrl
   import mdec_pkg::*;
#(
   parameter int unsigned SUB_W   = 3,
   parameter bit          LINK_EN = 1'b1
) (
   input  iclass_e          cls_i,
   input  logic [SUB_W-1:0] sub_i,
   output ctrl_t            ctrl_o
);

   localparam logic [SUB_W-1:0] K_ADDI  = SUB_W'(SUB_ADDI);
   localparam logic [SUB_W-1:0] K_LOAD  = SUB_W'(SUB_LOAD);
   localparam logic [SUB_W-1:0] K_STORE = SUB_W'(SUB_STORE);
   localparam logic [SUB_W-1:0] K_BR    = SUB_W'(SUB_BR);
   localparam logic [SUB_W-1:0] K_LOGI  = SUB_W'(SUB_LOGI);
   localparam logic [SUB_W-1:0] K_JMP   = SUB_W'(SUB_JMP);
   localparam logic [SUB_W-1:0] K_JAL   = SUB_W'(SUB_JAL);

   generate
      if (SUB_W < 3) begin : g_bad_sub_w
         $error("mdec_ctrl: SUB_W too narrow for the immediate sub-opcodes");
      end
   endgenerate

   logic link_hit;

   generate
      if (LINK_EN) begin : g_link
         assign link_hit = (sub_i == K_JAL);
      end else begin : g_nolink
         assign link_hit = 1'b0;
      end
   endgenerate

   always_comb begin
      ctrl_o = '0;
      unique case (cls_i)
         CLS_REG: begin
            ctrl_o.reg_we = 1'b1;
            ctrl_o.dst    = DST_RD;
            ctrl_o.alu_op = AOP_FUNCT;
         end
         CLS_IMM: begin
            if (sub_i == K_ADDI || sub_i == K_LOGI) begin
               ctrl_o.reg_we      = 1'b1;
               ctrl_o.alu_src_imm = 1'b1;
               ctrl_o.alu_op      = (sub_i == K_LOGI) ? AOP_LOGIC : AOP_ADD;
            end else if (sub_i == K_LOAD) begin
               ctrl_o.reg_we      = 1'b1;
               ctrl_o.alu_src_imm = 1'b1;
               ctrl_o.mem_rd      = 1'b1;
               ctrl_o.mem_to_reg  = 1'b1;
            end else if (sub_i == K_STORE) begin
               ctrl_o.alu_src_imm = 1'b1;
               ctrl_o.mem_wr      = 1'b1;
            end else if (sub_i == K_BR) begin
               ctrl_o.branch = 1'b1;
               ctrl_o.alu_op = AOP_SUB;
            end
         end
         CLS_JMP: begin
            if (sub_i == K_JMP) begin
               ctrl_o.jump = 1'b1;
            end else if (link_hit) begin
               ctrl_o.jump   = 1'b1;
               ctrl_o.reg_we = 1'b1;
               ctrl_o.dst    = DST_RA;
            end
         end
         default: ctrl_o = '0;
      endcase
   end

   always_comb begin
      p_mem_excl_r5: assert (!(ctrl_o.mem_rd && ctrl_o.mem_wr))
         else $error("R5 memory read and write together");
      p_branch_quiet_r6: assert (!ctrl_o.branch || (!ctrl_o.reg_we && !ctrl_o.mem_wr))
         else $error("R6 branch with a write enable");
   end

endmodule

// File: rtl/mdec_dest.sv
module mdec_dest
   import mdec_pkg::*;
#(
   parameter int unsigned REG_W = 7
) (
   input  dst_e             dst_i,
   input  logic [REG_W-1:0] rt_i,
   input  logic [REG_W-1:0] rd_i,
   output logic [REG_W-1:0] wr_reg_o
);

   localparam logic [REG_W-1:0] RA_IDX = {REG_W{1'b1}};

   generate
      if (REG_W < 2) begin : g_bad_reg_w
         $error("mdec_dest: REG_W too small");
      end
   endgenerate

   always_comb begin
      unique case (dst_i)
         DST_RD:  wr_reg_o = rd_i;
         DST_RA:  wr_reg_o = RA_IDX;
         default: wr_reg_o = rt_i;
      endcase
   end

endmodule

// File: rtl/mdec_main.sv
module mdec_main
   import mdec_pkg::*;
#(
   parameter int unsigned INSTR_W = 32,
   parameter int unsigned OP_W    = 5,
   parameter int unsigned REG_W   = 7,
   parameter bit          LINK_EN = 1'b1
) (
   input  logic [INSTR_W-1:0] instr_i,
   output logic [1:0]         cls_o,
   output logic               reg_we_o,
   output logic [1:0]         dst_sel_o,
   output logic [REG_W-1:0]   wr_reg_o,
   output logic               alu_src_imm_o,
   output logic               mem_rd_o,
   output logic               mem_wr_o,
   output logic               mem_to_reg_o,
   output logic               branch_o,
   output logic               jump_o,
   output logic [1:0]         alu_op_o
);

   localparam int unsigned SUB_W  = OP_W - 2;
   localparam int unsigned OP_LO  = INSTR_W - OP_W;
   localparam int unsigned RS_LO  = OP_LO - REG_W;
   localparam int unsigned RT_LO  = RS_LO - REG_W;
   localparam int unsigned RD_LO  = RT_LO - REG_W;
   localparam logic [REG_W-1:0] RA_IDX = {REG_W{1'b1}};

   generate
      if (INSTR_W < OP_W + 3 * REG_W + 1) begin : g_bad_fields
         $error("mdec_main: instruction too narrow for opcode and three register fields");
      end
   endgenerate

   logic [OP_W-1:0]  op;
   logic [REG_W-1:0] rt_f;
   logic [REG_W-1:0] rd_f;
   iclass_e          cls;
   ctrl_t            ctrl;
   logic             unused_bits;

   assign op   = instr_i[INSTR_W-1:OP_LO];
   assign rt_f = instr_i[RS_LO-1:RT_LO];
   assign rd_f = instr_i[RT_LO-1:RD_LO];
   assign unused_bits = ^{instr_i[OP_LO-1:RS_LO], instr_i[RD_LO-1:0]};

   mdec_class #(.OP_W(OP_W)) class_i (
      .op_i  (op),
      .cls_o (cls)
   );

   mdec_ctrl #(.SUB_W(SUB_W), .LINK_EN(LINK_EN)) ctrl_i (
      .cls_i  (cls),
      .sub_i  (op[SUB_W-1:0]),
      .ctrl_o (ctrl)
   );

   mdec_dest #(.REG_W(REG_W)) dest_i (
      .dst_i    (ctrl.dst),
      .rt_i     (rt_f),
      .rd_i     (rd_f),
      .wr_reg_o (wr_reg_o)
   );

   assign cls_o         = cls;
   assign reg_we_o      = ctrl.reg_we;
   assign dst_sel_o     = ctrl.dst;
   assign alu_src_imm_o = ctrl.alu_src_imm;
   assign mem_rd_o      = ctrl.mem_rd;
   assign mem_wr_o      = ctrl.mem_wr;
   assign mem_to_reg_o  = ctrl.mem_to_reg;
   assign branch_o      = ctrl.branch;
   assign jump_o        = ctrl.jump;
   assign alu_op_o      = ctrl.alu_op;

   always_comb begin
      p_rtype_ctrl_r2: assert (cls_o != 2'd1 ||
                               (reg_we_o && alu_op_o == AOP_FUNCT && !jump_o))
         else $error("R2 register class control wrong");
      p_link_dest_r9: assert (!(jump_o && reg_we_o) || wr_reg_o == RA_IDX)
         else $error("R9 linking jump not aimed at return register");
      p_free_quiet_r10: assert (!(cls_o == 2'd2 && op[SUB_W-1:0] > SUB_W'(SUB_LOGI)) ||
                                !(reg_we_o || mem_rd_o || mem_wr_o || branch_o || jump_o))
         else $error("R10 unassigned immediate opcode raised an enable");
   end

endmodule

// File: tb/mdec_main_tb_top.sv
module mdec_main_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] instr;
   logic [1:0]  cls;
   logic        reg_we;
   logic [1:0]  dst_sel;
   logic [6:0]  wr_reg;
   logic        alu_src_imm, mem_rd, mem_wr, mem_to_reg, branch, jump;
   logic [1:0]  alu_op;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   mdec_main dut_i (
      .instr_i       (instr),
      .cls_o         (cls),
      .reg_we_o      (reg_we),
      .dst_sel_o     (dst_sel),
      .wr_reg_o      (wr_reg),
      .alu_src_imm_o (alu_src_imm),
      .mem_rd_o      (mem_rd),
      .mem_wr_o      (mem_wr),
      .mem_to_reg_o  (mem_to_reg),
      .branch_o      (branch),
      .jump_o        (jump),
      .alu_op_o      (alu_op)
   );

   // expected word: {cls[1:0], reg_we, dst[1:0], alu_src_imm, mem_rd, mem_wr,
   //                 mem_to_reg, branch, jump, alu_op[1:0]}
   localparam int NV = 17;
   localparam logic [4:0] V_OP [NV] = '{
      5'b00000, 5'b00001, 5'b00010, 5'b00111,
      5'b01000, 5'b01101, 5'b10000, 5'b10111,
      5'b11000, 5'b11001, 5'b11010, 5'b11011, 5'b11100,
      5'b11101, 5'b11111, 5'b01111, 5'b00100
   };
   localparam logic [12:0] V_EXP [NV] = '{
      13'b00_0_00_0_0_0_0_0_1_00, // R8 jump
      13'b00_1_10_0_0_0_0_0_1_00, // R9 link
      13'b00_0_00_0_0_0_0_0_0_00, // R10
      13'b00_0_00_0_0_0_0_0_0_00, // R10
      13'b01_1_01_0_0_0_0_0_0_10, // R2
      13'b01_1_01_0_0_0_0_0_0_10, // R2
      13'b01_1_01_0_0_0_0_0_0_10, // R2
      13'b01_1_01_0_0_0_0_0_0_10, // R2
      13'b10_1_00_1_0_0_0_0_0_00, // R7 addi
      13'b10_1_00_1_1_0_1_0_0_00, // R4 load
      13'b10_0_00_1_0_1_0_0_0_00, // R5 store
      13'b10_0_00_0_0_0_0_1_0_01, // R6 branch
      13'b10_1_00_1_0_0_0_0_0_11, // R7 logical
      13'b10_0_00_0_0_0_0_0_0_00, // R10
      13'b10_0_00_0_0_0_0_0_0_00, // R10
      13'b01_1_01_0_0_0_0_0_0_10, // R1 boundary
      13'b00_0_00_0_0_0_0_0_0_00  // R10
   };

   function automatic logic [31:0] mk(input logic [4:0] op, input logic [6:0] rt,
                                      input logic [6:0] rd);
      return {op, 7'h2A, rt, rd, 6'h15};
   endfunction

   function automatic logic [12:0] act_word();
      return {cls, reg_we, dst_sel, alu_src_imm, mem_rd, mem_wr,
              mem_to_reg, branch, jump, alu_op};
   endfunction

   task automatic apply(input logic [31:0] w);
      @(posedge clk);
      instr = w;
      @(negedge clk);
   endtask

   task automatic chk_ctrl(input logic [12:0] exp, input string tag);
      checks++;
      if (act_word() !== exp) begin
         errors++;
         $display("FAIL %s instr=%h actual=%b expected=%b", tag, instr, act_word(), exp);
      end
   endtask

   task automatic chk_reg(input logic [6:0] exp, input string tag);
      checks++;
      if (wr_reg !== exp) begin
         errors++;
         $display("FAIL %s instr=%h wr_reg actual=%0d expected=%0d", tag, instr, wr_reg, exp);
      end
   endtask

   initial begin
      #(20 * 5000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      instr = 32'h0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // reset state: all-zero word decodes as plain jump (R8, R1)
      chk_ctrl(13'b00_0_00_0_0_0_0_0_1_00, "R8 reset-state");
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         apply(mk(V_OP[i], 7'd9, 7'd5));
         chk_ctrl(V_EXP[i], $sformatf("R1 table op=%b", V_OP[i]));
      end

      // R3 destination fields
      apply(mk(5'b01010, 7'd9, 7'd5));
      chk_reg(7'd5, "R3 rtype rd");
      apply(mk(5'b11000, 7'd9, 7'd5));
      chk_reg(7'd9, "R3 addi rt");
      apply(mk(5'b11001, 7'd126, 7'd0));
      chk_reg(7'd126, "R3 load rt");

      // R9 jump and register write in one cycle, destination forced to 127
      apply(mk(5'b00001, 7'd0, 7'd3));
      checks++;
      if (!(jump && reg_we && wr_reg == 7'd127)) begin
         errors++;
         $display("FAIL R9 link jump=%b we=%b wr_reg=%0d expected 1 1 127",
                  jump, reg_we, wr_reg);
      end
      // load: memory read and write-back together, no memory write (R4)
      apply(mk(5'b11001, 7'd1, 7'd1));
      checks++;
      if (!(mem_rd && mem_to_reg && reg_we && !mem_wr)) begin
         errors++;
         $display("FAIL R4 load rd=%b m2r=%b we=%b wr=%b expected 1 1 1 0",
                  mem_rd, mem_to_reg, reg_we, mem_wr);
      end

      // R11 lower bits have no effect on control
      apply({5'b11010, 27'h7FF_FFFF});
      chk_ctrl(13'b10_0_00_1_0_1_0_0_0_00, "R11 store ones");
      apply({5'b11010, 27'h0});
      chk_ctrl(13'b10_0_00_1_0_1_0_0_0_00, "R11 store zeros");
      apply({5'b00000, 27'h555_5555});
      chk_ctrl(13'b00_0_00_0_0_0_0_0_1_00, "R11 jump pattern");

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule